// File: doc/BRIEF.md
# Supervisor Mode Sequencer with Preemption Timer

This block tracks whether a small 8-bit CPU running a multitasking kernel is in kernel or user mode, and produces the periodic non-maskable interrupt that preempts user processes. Every vector fetch puts the machine into kernel mode. Vector fetches happen on reset, on a software break, on a maskable interrupt and on a non-maskable interrupt. Leaving kernel mode takes two stages. A write to the process-number register clears an internal "armed" flag. The visible kernel flag then drops only at the end of a later opcode-fetch cycle. This lets the kernel pick the next process and still run its return-from-interrupt instruction in kernel mode.

The number of opcode fetches between the process-number write and the exit is set by `EXIT_FETCHES`, which may be 1 or 2. A value of 2 gives the kernel one more instruction, for example to restore the register it used for the write. A down-counter reloads from `TICK_RELOAD`. It runs only while the visible flag is clear and is held at its reload value in kernel mode, so no preemption interrupt can reach the kernel. The block runs on the CPU clock, one clock per bus cycle, at up to about 10 MHz with no stretched cycles.

Top module: `supv_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `kmode` is 1 and `nmi_n` is 1.
- R2: A cycle with `vec_fetch` high leaves `kmode` at 1 after that clock edge, and it cancels any exit that is in progress. A later `op_fetch` does not clear `kmode` until a new `pid_wr` has been seen.
- R3: A `pid_wr` cycle on its own does not change `kmode`. `kmode` stays 1 during every cycle up to and including the opcode fetch that completes the exit.
- R4: With `EXIT_FETCHES`=1, `kmode` goes to 0 after the edge that ends the first `op_fetch` cycle following a `pid_wr` cycle, however many idle cycles lie between them. `op_fetch` cycles before the `pid_wr` have no effect.
- R5: With `EXIT_FETCHES`=2, `kmode` stays 1 after the first such `op_fetch` cycle and goes to 0 after the second.
- R6: When `vec_fetch` and `pid_wr` are high in the same cycle, the vector fetch wins. No exit follows from that write.
- R7: While `kmode` is 1, `nmi_n` stays 1 and the timer stays at its reload value.
- R8: In user mode, `nmi_n` is low for exactly one cycle. The first low cycle is the `TICK_RELOAD`-th cycle after the first user-mode cycle, and later low cycles repeat every `TICK_RELOAD`+1 cycles.
- R9: In user mode, `op_fetch` and `pid_wr` leave `kmode` at 0. Only `vec_fetch` sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_fetch | input | 1 | High during a cycle that reads an interrupt, break or reset vector |
| op_fetch | input | 1 | High during an opcode-fetch cycle |
| pid_wr | input | 1 | High during a write to the process-number register |
| kmode | output | 1 | 1 = kernel (supervisor) mode, 0 = user mode |
| nmi_n | output | 1 | Active-low preemption interrupt request, one cycle wide |

## Verification
If the armed flag or the fetch countdown is wrong, `kmode` falls one opcode fetch too early or too late. The error shows at the edge that ends that fetch, so the sweep checks `kmode` on every cycle of the exit window for several gap lengths and for both exit depths. A timer that is not held, or that reloads with the wrong value, moves the first `nmi_n` pulse away from the cycle `TICK_RELOAD` after exit, or shows a pulse during kernel mode. The bench therefore compares `nmi_n` with the computed value on every cycle from exit through two full periods.

// File: rtl/supv_seq.sv
module supv_seq #(
  parameter int TICK_RELOAD  = 20000,
  parameter int EXIT_FETCHES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vec_fetch,
  input  logic op_fetch,
  input  logic pid_wr,
  output logic kmode,
  output logic nmi_n
);

  localparam int CW = (TICK_RELOAD < 2) ? 1 : $clog2(TICK_RELOAD + 1);
  localparam int FW = (EXIT_FETCHES < 2) ? 1 : $clog2(EXIT_FETCHES + 1);
  localparam logic [CW-1:0] RELOAD_V = CW'(TICK_RELOAD);
  localparam logic [FW-1:0] FETCH_V  = FW'(EXIT_FETCHES);

  logic          armed;
  logic [FW-1:0] left_q;
  logic [CW-1:0] cnt_q;
  logic          step, last_step;

  assign step      = op_fetch && !armed && (left_q != '0);
  assign last_step = step && (left_q == FW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || vec_fetch) begin
      armed  <= 1'b1;
      left_q <= '0;
    end else if (pid_wr) begin
      armed  <= 1'b0;
      left_q <= FETCH_V;
    end else if (step) begin
      left_q <= left_q - FW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || vec_fetch) kmode <= 1'b1;
    else if (last_step)      kmode <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || kmode || cnt_q == '0) cnt_q <= RELOAD_V;
    else                                cnt_q <= cnt_q - CW'(1);
  end

  assign nmi_n = !(!kmode && cnt_q == '0);

  // R2
  vec_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |=> (kmode && armed));

  // R3
  exit_on_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kmode) |-> ($past(op_fetch) && !$past(armed) && !$past(vec_fetch)));

  // R6
  vec_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch && pid_wr) |=> armed);

  // R7
  held_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kmode) |-> (cnt_q == RELOAD_V));

  // R8
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_n |=> nmi_n);

endmodule

// File: tb/supv_seq_tb.sv
module supv_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RLD = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vec_fetch = 1'b0, op_fetch = 1'b0, pid_wr = 1'b0;
  logic k1, n1, k2, n2;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supv_seq #(.TICK_RELOAD(RLD), .EXIT_FETCHES(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .vec_fetch(vec_fetch), .op_fetch(op_fetch),
    .pid_wr(pid_wr), .kmode(k1), .nmi_n(n1));

  supv_seq #(.TICK_RELOAD(RLD), .EXIT_FETCHES(2)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .vec_fetch(vec_fetch), .op_fetch(op_fetch),
    .pid_wr(pid_wr), .kmode(k2), .nmi_n(n2));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic v, input logic s, input logic p);
    vec_fetch = v; op_fetch = s; pid_wr = p;
    @(posedge clk); #1;
    vec_fetch = 0; op_fetch = 0; pid_wr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) begin @(posedge clk); #1; chk("R1", k1, 1); chk("R1", n1, 1); end
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1", k1, 1); chk("R1", n1, 1);
    // R4/R7: fetches in kernel mode before any PID write do nothing, no NMI
    for (int i = 0; i < 3 * RLD; i++) begin
      cyc(0, (i % 2) == 0, 0);
      chk("R4", k1, 1); chk("R7", n1, 1); chk("R7", n2, 1);
    end

    for (int g = 0; g < 4; g++) begin
      cyc(0, 0, 1);
      chk("R3", k1, 1); chk("R3", k2, 1);
      for (int j = 0; j < g; j++) begin
        cyc(0, 0, 0);
        chk("R3", k1, 1); chk("R3", k2, 1);
      end
      cyc(0, 1, 0);
      chk("R4", k1, 0); chk("R5", k2, 1); chk("R7", n2, 1);
      for (int j = 0; j < g; j++) begin
        cyc(0, 0, 0);
        chk("R5", k2, 1);
      end
      cyc(0, 1, 0);
      chk("R5", k2, 0);
      // u_dut left at edge L1, u_dut2 at edge L2 = L1 + g + 1
      for (int k = 1; k <= 2 * RLD + 3; k++) begin
        int t1, t2;
        cyc(0, (k % 3) == 0, (k == 4));
        t1 = k + g + 1;
        t2 = k;
        chk("R9", k1, 0); chk("R9", k2, 0);
        chk("R8", n1, !((t1 % (RLD + 1)) == RLD));
        chk("R8", n2, !((t2 % (RLD + 1)) == RLD));
      end
      cyc(1, 0, 0);
      chk("R2", k1, 1); chk("R2", k2, 1); chk("R7", n1, 1); chk("R7", n2, 1);
    end

    // R6 simultaneous vector fetch and PID write
    cyc(1, 0, 1);
    chk("R6", k1, 1);
    repeat (3) begin cyc(0, 1, 0); chk("R6", k1, 1); chk("R6", k2, 1); end

    // R2 vector fetch during exit window cancels handoff
    cyc(0, 0, 1);
    cyc(0, 1, 0);
    chk("R5", k2, 1);
    cyc(1, 0, 0);
    repeat (3) begin cyc(0, 1, 0); chk("R2", k1, 1); chk("R2", k2, 1); end
    cyc(0, 0, 1);
    cyc(1, 0, 0);
    repeat (3) begin cyc(0, 1, 0); chk("R2", k1, 1); end
    for (int i = 0; i < 2 * RLD; i++) begin
      cyc(0, 0, 0);
      chk("R7", n1, 1); chk("R7", n2, 1);
    end

    // R1 reset from user mode
    cyc(0, 0, 1); cyc(0, 1, 0);
    chk("R4", k1, 0);
    rst_n = 0;
    @(posedge clk); #1;
    chk("R1", k1, 1); chk("R1", n1, 1);
    rst_n = 1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule